// File: doc/BRIEF.md
# SPI Bus Word Sniffer

This block is a passive observer that sits beside a four-wire SPI link (serial clock, chip select, controller-to-peripheral data, peripheral-to-controller data) and rebuilds the words carried in both directions at once. It only listens and never drives a bus wire. It samples the wires with its own faster system clock, passes them through a synchroniser, and finds serial-clock transitions by comparing each synchronised sample with the one before it.

Configuration inputs set the clock idle level and phase, which together choose one of the four SPI modes. They also set the bit order, the word length and whether chip select is asserted high or low. For each finished word the block presents the outgoing and incoming words together, with a one-cycle valid strobe and a flag that is set if chip select was inactive at any captured bit of that word. It also emits an event on every chip-select level change and keeps a running count of finished words.

Top module: `spi_sniffer`

## Requirements
- R1: A bit is captured on a rising serial-clock edge when `cfg_cpol` equals `cfg_cpha` (modes 0 and 3), and on a falling edge otherwise (modes 1 and 2). `cfg_cpol` is the idle clock level. Phase 0 means data is valid at the leading edge and phase 1 means it is valid at the trailing edge.
- R2: The `bus_mosi` and `bus_miso` bits are taken at the same capture edge into two separate words, `word_mosi` and `word_miso`.
- R3: With `cfg_lsb_first`=0 the k-th captured bit (k from 0) lands at bit position L-1-k, where L is the effective length. With `cfg_lsb_first`=1 it lands at position k.
- R4: A word is output only after exactly L bits have been captured. `word_valid` is high for a single cycle. `word_mosi`, `word_miso` and `word_cs_warn` update in that same cycle. Bits at L and above read 0. After the word, capture restarts at k=0.
- R5: The effective length L is `cfg_word_len`, except that 0 becomes 1 and any value above MAX_WORD (32 by default) becomes MAX_WORD.
- R6: `cfg_cs_active_high`=0 makes chip select active low, and 1 makes it active high. If chip select is inactive at any captured bit of a word, `word_cs_warn` is 1 with that word. Otherwise it is 0. The flag starts clear for every new word.
- R7: Each change of the synchronised chip-select level produces a one-cycle `cs_evt` pulse, with `cs_evt_old` and `cs_evt_new` giving the levels before and after the change. This holds whether or not a word is in progress.
- R8: `word_count` rises by exactly one in each cycle where `word_valid` is high, and holds its value otherwise.
- R9: After reset all outputs are 0. Wire levels that were present before or during reset cause neither a capture nor a chip-select event.
- R10: Each real serial-clock edge gives at most one capture, however many system cycles it stays at its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial-clock idle level |
| cfg_cpha | input | 1 | Phase: 0 leading-edge data, 1 trailing-edge data |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cs_active_high | input | 1 | 1 = chip select asserted high |
| cfg_word_len | input | LEN_W (6) | Requested bits per word, clamped into 1..MAX_WORD |
| bus_sck | input | 1 | Observed serial clock |
| bus_cs | input | 1 | Observed chip select |
| bus_mosi | input | 1 | Observed controller-to-peripheral data |
| bus_miso | input | 1 | Observed peripheral-to-controller data |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_mosi | output | MAX_WORD (32) | Rebuilt controller-to-peripheral word |
| word_miso | output | MAX_WORD (32) | Rebuilt peripheral-to-controller word |
| word_cs_warn | output | 1 | Chip select was inactive at a captured bit of this word |
| cs_evt | output | 1 | One-cycle chip-select change event |
| cs_evt_old | output | 1 | Chip-select level before the change |
| cs_evt_new | output | 1 | Chip-select level after the change |
| word_count | output | CNT_W (16) | Number of finished words since reset |

## Verification
Assertions check the following on every cycle:
- the single-cycle strobe;
- the word counter stepping in lockstep with the strobe;
- zero bits above the effective length;
- the clamped length range;
- old and new chip-select levels that differ at each event;
- no two captures in a row from one clock level.

Only the bench's scenarios can show the rest: that the right edge is chosen in each of the four modes, that bits land in the right positions for each order, that words match what a modelled controller sent, that the warning sticks across a word and clears after it, and that reset-time wire levels produce no spurious activity.

// File: rtl/spi_snf_pkg.sv
package spi_snf_pkg;

   typedef enum logic {
      SNF_EDGE_FALL = 1'b0,
      SNF_EDGE_RISE = 1'b1
   } snf_edge_e;

   // Idle level equal to phase means data is taken on the rising level.
   function automatic snf_edge_e snf_capture_edge(input logic cpol, input logic cpha);
      return (cpol == cpha) ? SNF_EDGE_RISE : SNF_EDGE_FALL;
   endfunction

   // Chip select is inactive when its level differs from the asserted level.
   function automatic logic snf_cs_inactive(input logic cs_level, input logic active_high);
      return active_high ? ~cs_level : cs_level;
   endfunction

endpackage

// File: rtl/spi_snf_sync.sv
module spi_snf_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             ready
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_snf_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_snf_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0]  stg [STAGES];
   logic [STAGES-1:0] fill;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   // Marks when the last stage holds a genuine sample rather than the reset value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill <= '0;
      else        fill <= {fill[STAGES-2:0], 1'b1};
   end

   assign dout  = stg[STAGES-1];
   assign ready = fill[STAGES-1];

   AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready); // R9

endmodule

// File: rtl/spi_snf_edge.sv
module spi_snf_edge
   import spi_snf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic sck_s,
   input  logic cs_s,
   input  logic cfg_cpol,
   input  logic cfg_cpha,
   output logic cap,
   output logic cs_evt,
   output logic cs_evt_old,
   output logic cs_evt_new
);

   logic      sck_prev;
   logic      cs_prev;
   logic      armed;
   logic      live;
   logic      sck_moved;
   logic      cs_moved;
   snf_edge_e want;

   // The first real sample only loads the history, so reset-time levels make no edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         cs_prev  <= 1'b0;
         armed    <= 1'b0;
      end else if (ready) begin
         sck_prev <= sck_s;
         cs_prev  <= cs_s;
         armed    <= 1'b1;
      end
   end

   always_comb begin
      live      = armed & ready;
      want      = snf_capture_edge(cfg_cpol, cfg_cpha);
      sck_moved = live & (sck_s != sck_prev);
      cs_moved  = live & (cs_s != cs_prev);
      cap       = sck_moved & (sck_s == logic'(want));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_evt     <= 1'b0;
         cs_evt_old <= 1'b0;
         cs_evt_new <= 1'b0;
      end else begin
         cs_evt <= cs_moved;
         if (cs_moved) begin
            cs_evt_old <= cs_prev;
            cs_evt_new <= cs_s;
         end
      end
   end

   AST_EVT_LEVELS_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
      cs_evt |-> (cs_evt_old != cs_evt_new)); // R7

   AST_ONE_CAPTURE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> !cap); // R10

endmodule

// File: rtl/spi_snf_assemble.sv
module spi_snf_assemble #(
   parameter int MAX_WORD = 32,
   parameter int CNT_W    = 16,
   parameter int LEN_W    = $clog2(MAX_WORD + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic                mosi_b,
   input  logic                miso_b,
   input  logic                cs_inact,
   input  logic [LEN_W-1:0]    len_eff,
   input  logic                lsb_first,
   output logic                word_valid,
   output logic [MAX_WORD-1:0] word_mosi,
   output logic [MAX_WORD-1:0] word_miso,
   output logic                word_cs_warn,
   output logic [CNT_W-1:0]    word_count
);

   if (MAX_WORD < 1) begin : g_bad_max
      $error("spi_snf_assemble: MAX_WORD must be at least 1");
   end
   if (LEN_W < $clog2(MAX_WORD + 1)) begin : g_bad_lenw
      $error("spi_snf_assemble: LEN_W too narrow for MAX_WORD");
   end

   logic [LEN_W-1:0]    bit_cnt;
   logic [LEN_W-1:0]    pos;
   logic [LEN_W:0]      cnt_next;
   logic                last;
   logic [MAX_WORD-1:0] sel;
   logic [MAX_WORD-1:0] keep_mask;
   logic [MAX_WORD-1:0] acc_mo, acc_mi;
   logic [MAX_WORD-1:0] nxt_mo, nxt_mi;
   logic                acc_warn;

   always_comb begin
      pos      = lsb_first ? bit_cnt : LEN_W'(len_eff - bit_cnt - 1'b1);
      cnt_next = {1'b0, bit_cnt} + 1'b1;
      last     = cnt_next >= {1'b0, len_eff};
   end

   // One-hot position decode and in-length mask, one slice per word bit.
   for (genvar i = 0; i < MAX_WORD; i++) begin : g_bit
      assign sel[i]       = (pos == LEN_W'(i));
      assign keep_mask[i] = (LEN_W'(i) < len_eff);
   end

   always_comb begin
      nxt_mo = acc_mo | (sel & {MAX_WORD{mosi_b}});
      nxt_mi = acc_mi | (sel & {MAX_WORD{miso_b}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt      <= '0;
         acc_mo       <= '0;
         acc_mi       <= '0;
         acc_warn     <= 1'b0;
         word_valid   <= 1'b0;
         word_mosi    <= '0;
         word_miso    <= '0;
         word_cs_warn <= 1'b0;
         word_count   <= '0;
      end else begin
         word_valid <= 1'b0;
         if (cap) begin
            if (last) begin
               word_valid   <= 1'b1;
               word_mosi    <= nxt_mo;
               word_miso    <= nxt_mi;
               word_cs_warn <= acc_warn | cs_inact;
               word_count   <= word_count + 1'b1;
               bit_cnt      <= '0;
               acc_mo       <= '0;
               acc_mi       <= '0;
               acc_warn     <= 1'b0;
            end else begin
               bit_cnt  <= LEN_W'(cnt_next);
               acc_mo   <= nxt_mo;
               acc_mi   <= nxt_mi;
               acc_warn <= acc_warn | cs_inact;
            end
         end
      end
   end

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid); // R4

   AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (((word_mosi | word_miso) & ~$past(keep_mask)) == '0)); // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (word_count == CNT_W'($past(word_count) + 1'b1))); // R8

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable(word_count)); // R8

endmodule

// File: rtl/spi_sniffer.sv
module spi_sniffer
   import spi_snf_pkg::*;
#(
   parameter int MAX_WORD    = 32,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = $clog2(MAX_WORD + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic                cfg_lsb_first,
   input  logic                cfg_cs_active_high,
   input  logic [LEN_W-1:0]    cfg_word_len,
   input  logic                bus_sck,
   input  logic                bus_cs,
   input  logic                bus_mosi,
   input  logic                bus_miso,
   output logic                word_valid,
   output logic [MAX_WORD-1:0] word_mosi,
   output logic [MAX_WORD-1:0] word_miso,
   output logic                word_cs_warn,
   output logic                cs_evt,
   output logic                cs_evt_old,
   output logic                cs_evt_new,
   output logic [CNT_W-1:0]    word_count
);

   localparam int NWIRE = 4;
   localparam int W_SCK = 0;
   localparam int W_CS  = 1;
   localparam int W_MO  = 2;
   localparam int W_MI  = 3;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("spi_sniffer: CNT_W must be at least 1");
   end

   logic [NWIRE-1:0] raw;
   logic [NWIRE-1:0] syn;
   logic             syn_ready;
   logic             cap;
   logic             cs_inact;
   logic [LEN_W-1:0] len_eff;

   assign raw = {bus_miso, bus_mosi, bus_cs, bus_sck};

   // Length clamp into 1..MAX_WORD.
   always_comb begin
      if (cfg_word_len == '0)
         len_eff = LEN_W'(1);
      else if (cfg_word_len > LEN_W'(MAX_WORD))
         len_eff = LEN_W'(MAX_WORD);
      else
         len_eff = cfg_word_len;
   end

   assign cs_inact = snf_cs_inactive(syn[W_CS], cfg_cs_active_high);

   spi_snf_sync #(
      .WIDTH  (NWIRE),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw),
      .dout  (syn),
      .ready (syn_ready)
   );

   spi_snf_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready      (syn_ready),
      .sck_s      (syn[W_SCK]),
      .cs_s       (syn[W_CS]),
      .cfg_cpol   (cfg_cpol),
      .cfg_cpha   (cfg_cpha),
      .cap        (cap),
      .cs_evt     (cs_evt),
      .cs_evt_old (cs_evt_old),
      .cs_evt_new (cs_evt_new)
   );

   spi_snf_assemble #(
      .MAX_WORD (MAX_WORD),
      .CNT_W    (CNT_W),
      .LEN_W    (LEN_W)
   ) u_asm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cap          (cap),
      .mosi_b       (syn[W_MO]),
      .miso_b       (syn[W_MI]),
      .cs_inact     (cs_inact),
      .len_eff      (len_eff),
      .lsb_first    (cfg_lsb_first),
      .word_valid   (word_valid),
      .word_mosi    (word_mosi),
      .word_miso    (word_miso),
      .word_cs_warn (word_cs_warn),
      .word_count   (word_count)
   );

   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (len_eff >= LEN_W'(1)) && (len_eff <= LEN_W'(MAX_WORD))); // R5

   AST_NO_CAPTURE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_ready |-> !cap && !word_valid && !cs_evt); // R9

endmodule

// File: tb/spi_sniffer_tb.sv
module spi_sniffer_tb;

   localparam int MAXW = 32;
   localparam int LW   = 6;
   localparam int HALF = 4;

   typedef struct packed {
      logic        cpol;
      logic        cpha;
      logic        lsb;
      logic        csh;
      logic [5:0]  len;
      logic [31:0] mo;
      logic [31:0] mi;
      logic [5:0]  glitch;   // 63 = no glitch
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 1'b0, 6'd8,  32'h000000A5, 32'h0000003C, 6'd63},
      '{1'b0, 1'b1, 1'b0, 1'b0, 6'd8,  32'h00000096, 32'h0000000F, 6'd63},
      '{1'b1, 1'b0, 1'b1, 1'b0, 6'd8,  32'h000000C3, 32'h00000081, 6'd63},
      '{1'b1, 1'b1, 1'b1, 1'b1, 6'd12, 32'h00000ABC, 32'h000005A5, 6'd63},
      '{1'b0, 1'b0, 1'b1, 1'b0, 6'd16, 32'h00001234, 32'h0000FEDC, 6'd63},
      '{1'b1, 1'b1, 1'b0, 1'b0, 6'd32, 32'hDEADBEEF, 32'h01234567, 6'd63},
      '{1'b0, 1'b1, 1'b0, 1'b1, 6'd5,  32'h00000015, 32'h0000000A, 6'd2},
      '{1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  32'h00000001, 32'h00000000, 6'd63},
      '{1'b0, 1'b0, 1'b0, 1'b0, 6'd40, 32'h89ABCDEF, 32'h76543210, 6'd63}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_cs_active_high = 1'b0;
   logic [LW-1:0]   cfg_word_len = 6'd8;
   logic            bus_sck = 1'b0, bus_cs = 1'b1, bus_mosi = 1'b0, bus_miso = 1'b0;
   logic            word_valid, word_cs_warn, cs_evt, cs_evt_old, cs_evt_new;
   logic [MAXW-1:0] word_mosi, word_miso;
   logic [15:0]     word_count;

   int n_checks = 0, n_fail = 0;
   int n_words = 0, n_evt = 0, n_multi = 0;
   logic prev_valid = 1'b0;
   logic [31:0] got_mo, got_mi;
   logic got_warn, ev_old, ev_new;
   bit done = 0;

   always #4 clk = ~clk;  // 125 MHz

   spi_sniffer u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_cpol (cfg_cpol), .cfg_cpha (cfg_cpha), .cfg_lsb_first (cfg_lsb_first),
      .cfg_cs_active_high (cfg_cs_active_high), .cfg_word_len (cfg_word_len),
      .bus_sck (bus_sck), .bus_cs (bus_cs), .bus_mosi (bus_mosi), .bus_miso (bus_miso),
      .word_valid (word_valid), .word_mosi (word_mosi), .word_miso (word_miso),
      .word_cs_warn (word_cs_warn), .cs_evt (cs_evt), .cs_evt_old (cs_evt_old),
      .cs_evt_new (cs_evt_new), .word_count (word_count)
   );

   // Output monitor, sampled at the falling system-clock edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid) begin
            n_words++;
            got_mo   = word_mosi;
            got_mi   = word_miso;
            got_warn = word_cs_warn;
            if (prev_valid) n_multi++;
         end
         if (cs_evt) begin
            n_evt++;
            ev_old = cs_evt_old;
            ev_new = cs_evt_new;
         end
      end
      prev_valid = word_valid;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic cs_off(input logic csh);
      return csh ? 1'b0 : 1'b1;
   endfunction

   function automatic int eff_len(input logic [5:0] l);
      if (l == 0) return 1;
      if (l > 32) return 32;
      return int'(l);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(6);
      n_words = 0; n_evt = 0; n_multi = 0;
   endtask

   // Controller model: one word in the configured mode and bit order.
   task automatic send_word(input int len, input logic [31:0] mo, input logic [31:0] mi,
                            input int glitch);
      for (int k = 0; k < len; k++) begin
         int b;
         b = cfg_lsb_first ? k : len - 1 - k;
         if (k == glitch) bus_cs = cs_off(cfg_cs_active_high);
         if (!cfg_cpha) begin
            bus_mosi = mo[b]; bus_miso = mi[b];
            tick(HALF);
            bus_sck = ~cfg_cpol;
            tick(HALF);
            bus_sck = cfg_cpol;
            tick(HALF);
         end else begin
            bus_sck = ~cfg_cpol;
            bus_mosi = mo[b]; bus_miso = mi[b];
            tick(HALF);
            bus_sck = cfg_cpol;
            tick(HALF);
         end
         if (k == glitch) bus_cs = ~cs_off(cfg_cs_active_high);
      end
   endtask

   initial begin
      // R9: reset with clock idle high and chip select inactive, then check outputs.
      cfg_cpol = 1'b1; cfg_cpha = 1'b1; bus_sck = 1'b1; bus_cs = 1'b1;
      do_reset();
      tick(10);
      chk(word_valid == 1'b0 && word_count == 16'd0, "R9 reset valid/count", {47'd0, word_valid, word_count}, 64'd0);
      chk(word_mosi == '0 && word_miso == '0, "R9 reset words", {word_mosi, word_miso}, 64'd0);
      chk(n_evt == 0 && !cs_evt, "R9 no event from reset levels", 64'(n_evt), 64'd0);
      chk(n_words == 0, "R9 no capture from reset levels", 64'(n_words), 64'd0);

      // Table walk: R1 modes, R2 both lines, R3 order, R4 length, R5 clamp, R6 warn/polarity, R7 events.
      for (int v = 0; v < NV; v++) begin
         int          l;
         logic [63:0] mask;
         int          gl;
         vec_t        t;
         t = VECS[v];
         l = eff_len(t.len);
         mask = (64'd1 << l) - 1;
         gl = (t.glitch == 6'd63) ? -1 : int'(t.glitch);
         cfg_cpol = t.cpol; cfg_cpha = t.cpha; cfg_lsb_first = t.lsb;
         cfg_cs_active_high = t.csh; cfg_word_len = t.len;
         bus_sck = t.cpol; bus_cs = cs_off(t.csh); bus_mosi = 1'b0; bus_miso = 1'b0;
         do_reset();
         bus_cs = ~cs_off(t.csh);
         tick(8);
         send_word(l, t.mo, t.mi, gl);
         tick(8);
         bus_cs = cs_off(t.csh);
         tick(8);
         chk(n_words == 1 && n_multi == 0, $sformatf("R4 row %0d one single-cycle word", v), 64'(n_words), 64'd1);
         chk(64'(got_mo) == (64'(t.mo) & mask), $sformatf("R1 R3 R5 row %0d mosi word", v), 64'(got_mo), 64'(t.mo) & mask);
         chk(64'(got_mi) == (64'(t.mi) & mask), $sformatf("R2 row %0d miso word", v), 64'(got_mi), 64'(t.mi) & mask);
         chk(got_warn == (gl >= 0), $sformatf("R6 row %0d warn flag", v), 64'(got_warn), 64'(gl >= 0));
         chk(n_evt == ((gl >= 0) ? 4 : 2), $sformatf("R7 row %0d event count", v), 64'(n_evt), (gl >= 0) ? 64'd4 : 64'd2);
         chk(ev_old == ~cs_off(t.csh) && ev_new == cs_off(t.csh), $sformatf("R7 row %0d last event levels", v),
             {62'd0, ev_old, ev_new}, {62'd0, ~cs_off(t.csh), cs_off(t.csh)});
      end

      // R8, R6: back-to-back words, warn clears after the flagged word.
      cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_cs_active_high = 1'b0; cfg_word_len = 6'd8;
      bus_sck = 1'b0; bus_cs = 1'b1;
      do_reset();
      bus_cs = 1'b0;
      tick(8);
      send_word(8, 32'h11, 32'h22, -1);
      tick(6);
      chk(got_warn == 1'b0 && got_mo == 32'h11, "R4 first back-to-back word", 64'(got_mo), 64'h11);
      send_word(8, 32'h5E, 32'hE5, 0);
      tick(6);
      chk(got_warn == 1'b1, "R6 warn on glitched word", 64'(got_warn), 64'd1);
      send_word(8, 32'h7F, 32'h80, -1);
      tick(6);
      chk(got_warn == 1'b0, "R6 warn cleared for next word", 64'(got_warn), 64'd0);
      chk(got_mo == 32'h7F && got_mi == 32'h80, "R4 restart at bit 0 after word", {got_mo, got_mi}, {32'h7F, 32'h80});
      chk(word_count == 16'd3 && n_words == 3, "R8 word count", 64'(word_count), 64'd3);
      chk(n_multi == 0, "R10 one capture per edge, no double strobe", 64'(n_multi), 64'd0);

      // R10: the clock held high for a long time still gives one bit.
      cfg_word_len = 6'd2;
      do_reset();
      bus_cs = 1'b0;
      bus_mosi = 1'b1; tick(4); bus_sck = 1'b1; tick(40); bus_sck = 1'b0; tick(4);
      chk(n_words == 0, "R10 long high level is one bit", 64'(n_words), 64'd0);
      bus_mosi = 1'b0; tick(4); bus_sck = 1'b1; tick(4); bus_sck = 1'b0; tick(8);
      chk(n_words == 1 && got_mo == 32'h2, "R10 two edges make the word", 64'(got_mo), 64'h2);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule